// File: doc/BRIEF.md
# Composite peripheral clock-enable generator

This block derives one peripheral clock-enable stream from four reference sources. Each reference is modelled as a one-cycle strobe in the system clock domain. A 2-bit source code picks one reference. Two integer divide stages are cascaded after it, and a gate stage follows them. The result is a single-cycle pulse on `clk_en`, and its period in source strobes is the product of the two divider codes. The output `out_valid` is high while the generator can produce pulses: the active divide product is nonzero and the gate is open.

Software controls the block through a small word-addressed register bank with a write strobe and a read strobe. Read data appears one cycle after the read strobe. The bank holds a source-select register, three divider registers and a disable register. A status register holds a sticky error flag, which is raised while a zero divide product is in force. A new select or divider setting is held in the registers until the current output period ends, and is only then moved into the running counters, so a setting change never truncates a period.

Parameters set the bit position of each field. Other parameters remove the source mux, either divide stage or the gate. A removed mux leaves a fixed crystal strobe as the source. A removed divide stage acts as a ratio of 1. A removed gate never blocks the output.

Top module: `clkgen_periph`

## Requirements
- R1: Registers sit at byte offsets 0x00 (select), 0x04, 0x08 and 0x0C (dividers), 0x14 (disable) and 0x18 (status). A write stores all 32 bits. A read strobe returns the register's value on `rdata` in the next cycle. An unmapped offset, or a cycle without a read strobe, gives 0 in the next cycle.
- R2: The 2-bit field at bit SEL_SHIFT (default 4) of the select register picks the source. Code i selects `ref_stb[i]`.
- R3: The pulse period on `clk_en` equals d1 × d2 source strobes. d1 is the 3-bit field at DIV1_SHIFT (default 3) and d2 is the 3-bit field at DIV2_SHIFT (default 0), both in the divider register chosen by DIV1_REG and DIV2_REG (default 0x08).
- R4: A divider code of 7 is decoded as 0. While the active product is zero, `clk_en` stays low and `out_valid` is low.
- R5: Status bit 0 is a sticky error flag, set while a zero product is active. Writing 1 to it clears it. If the set condition and the clear occur in the same cycle, the set wins.
- R6: A 1 in bit GATE_BIT (default 6) of the disable register holds `clk_en` and `out_valid` low. Clearing the bit resumes the output.
- R7: A change to the select or divider registers takes effect only at the end of the current output period, so the period in progress keeps its old length.
- R8: With MUX_EN=0 the source is `xtal_stb`. With DIV1_EN=0 or DIV2_EN=0, that stage divides by 1 whatever its register field holds.
- R9: After reset, `clk_en` is low, `out_valid` is high, the error flag is clear, each used divider field reads 1 and all other register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_stb | input | 4 | Reference source strobes |
| xtal_stb | input | 1 | Fixed crystal strobe used when the mux is removed |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| clk_en | output | 1 | Divided, gated clock-enable pulse |
| out_valid | output | 1 | High while pulses can be produced |

## Verification
The in-line assertions check the following on every cycle:
- The gate and a zero product both force `clk_en` low on the next cycle.
- The active configuration changes only at a period boundary.
- The divide counters stay below their active codes.
- The error flag holds until it is cleared.
- `rdata` is zero when no read was requested.

Other properties need whole periods to be measured, so only the bench scenarios can show them:
- The period length as the product of the two codes.
- Which source each select code picks.
- That the old period runs to its end after a write.
- The crystal-source bypass variant.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   localparam int unsigned REG_AW = 5;
   localparam int unsigned REG_DW = 32;
   localparam int unsigned CODE_W = 3;

   localparam logic [REG_AW-1:0] OFS_SEL  = 5'h00;
   localparam logic [REG_AW-1:0] OFS_DIVA = 5'h04;
   localparam logic [REG_AW-1:0] OFS_DIVB = 5'h08;
   localparam logic [REG_AW-1:0] OFS_DIVC = 5'h0C;
   localparam logic [REG_AW-1:0] OFS_DIS  = 5'h14;
   localparam logic [REG_AW-1:0] OFS_STAT = 5'h18;

   typedef logic [CODE_W-1:0] divcode_t;

   // codes above the largest legal ratio collapse to zero (idle)
   function automatic divcode_t div_decode(input logic [CODE_W-1:0] raw);
      return (raw > 3'd6) ? 3'd0 : raw;
   endfunction
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
   import clkgen_pkg::*;
#(
   parameter int unsigned SEL_SHIFT  = 4,
   parameter int unsigned DIV1_REG   = 2,
   parameter int unsigned DIV1_SHIFT = 3,
   parameter int unsigned DIV2_REG   = 2,
   parameter int unsigned DIV2_SHIFT = 0,
   parameter int unsigned GATE_BIT   = 6,
   parameter bit          DIV1_EN    = 1'b1,
   parameter bit          DIV2_EN    = 1'b1,
   parameter bit          GATE_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_DW-1:0] wdata,
   output logic [REG_DW-1:0] rdata,
   input  logic              err_set,
   output logic [1:0]        cfg_sel,
   output divcode_t          cfg_d1,
   output divcode_t          cfg_d2,
   output logic              gate_off
);
   localparam int unsigned NDIV = 3;

   function automatic logic [REG_DW-1:0] div_rst(input int unsigned idx);
      logic [REG_DW-1:0] v;
      v = '0;
      if (DIV1_REG == idx) v = v | (REG_DW'(1) << DIV1_SHIFT);
      if (DIV2_REG == idx) v = v | (REG_DW'(1) << DIV2_SHIFT);
      return v;
   endfunction

   if (SEL_SHIFT > REG_DW - 2)         $error("SEL_SHIFT out of range");
   if (DIV1_REG < 1 || DIV1_REG > NDIV) $error("DIV1_REG out of range");
   if (DIV2_REG < 1 || DIV2_REG > NDIV) $error("DIV2_REG out of range");
   if (DIV1_SHIFT > REG_DW - CODE_W)    $error("DIV1_SHIFT out of range");
   if (DIV2_SHIFT > REG_DW - CODE_W)    $error("DIV2_SHIFT out of range");
   if (GATE_BIT > REG_DW - 1)           $error("GATE_BIT out of range");

   logic [REG_DW-1:0]            sel_q, dis_q;
   logic [NDIV-1:0][REG_DW-1:0]  div_q;
   logic                         err_q;
   logic                         err_clr;

   assign err_clr = wr_en && (addr == OFS_STAT) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         dis_q <= '0;
         err_q <= 1'b0;
         for (int k = 0; k < NDIV; k++) div_q[k] <= div_rst(k + 1);
      end else begin
         if (wr_en && addr == OFS_SEL) sel_q <= wdata;
         if (wr_en && addr == OFS_DIS) dis_q <= wdata;
         for (int k = 0; k < NDIV; k++)
            if (wr_en && addr == OFS_DIVA + REG_AW'(4 * k)) div_q[k] <= wdata;
         err_q <= err_set | (err_q & ~err_clr);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else if (rd_en) begin
         case (addr)
            OFS_SEL:  rdata <= sel_q;
            OFS_DIVA: rdata <= div_q[0];
            OFS_DIVB: rdata <= div_q[1];
            OFS_DIVC: rdata <= div_q[2];
            OFS_DIS:  rdata <= dis_q;
            OFS_STAT: rdata <= {{(REG_DW-1){1'b0}}, err_q};
            default:  rdata <= '0;
         endcase
      end else rdata <= '0;
   end

   assign cfg_sel = sel_q[SEL_SHIFT +: 2];

   if (DIV1_EN) begin : g_d1
      assign cfg_d1 = div_decode(div_q[DIV1_REG-1][DIV1_SHIFT +: CODE_W]);
   end else begin : g_d1_byp
      assign cfg_d1 = 3'd1;
   end

   if (DIV2_EN) begin : g_d2
      assign cfg_d2 = div_decode(div_q[DIV2_REG-1][DIV2_SHIFT +: CODE_W]);
   end else begin : g_d2_byp
      assign cfg_d2 = 3'd1;
   end

   if (GATE_EN) begin : g_gate
      assign gate_off = dis_q[GATE_BIT];
   end else begin : g_gate_byp
      assign gate_off = 1'b0;
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr) |=> err_q); // R5
   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0)); // R1
endmodule

// File: rtl/clkgen_divchain.sv
module clkgen_divchain
   import clkgen_pkg::*;
#(
   parameter int unsigned NSRC = 4,
   localparam int unsigned SEL_W = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_stb,
   input  logic [SEL_W-1:0] cfg_sel,
   input  divcode_t         cfg_d1,
   input  divcode_t         cfg_d2,
   input  logic             gate_off,
   output logic             clk_en_o,
   output logic             run_o,
   output logic             err_set_o
);
   logic [SEL_W-1:0] act_sel;
   divcode_t         act_d1, act_d2;
   divcode_t         cnt1, cnt2;
   logic             stb, zero, t1, t2, bnd, fire;

   assign stb  = src_stb[act_sel];
   assign zero = (act_d1 == '0) || (act_d2 == '0);
   assign t1   = (cnt1 == act_d1 - 3'd1);
   assign t2   = (cnt2 == act_d2 - 3'd1);
   assign fire = stb && t1 && t2 && !zero;
   assign bnd  = zero || (stb && t1 && t2);

   assign err_set_o = bnd && ((cfg_d1 == '0) || (cfg_d2 == '0));
   assign run_o     = !zero && !gate_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel  <= '0;
         act_d1   <= 3'd1;
         act_d2   <= 3'd1;
         cnt1     <= '0;
         cnt2     <= '0;
         clk_en_o <= 1'b0;
      end else begin
         clk_en_o <= fire && !gate_off;
         if (bnd) begin
            act_sel <= cfg_sel;
            act_d1  <= cfg_d1;
            act_d2  <= cfg_d2;
            cnt1    <= '0;
            cnt2    <= '0;
         end else if (stb) begin
            if (t1) begin
               cnt1 <= '0;
               cnt2 <= cnt2 + 3'd1;
            end else begin
               cnt1 <= cnt1 + 3'd1;
            end
         end
      end
   end

   AST_GATE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      gate_off |=> !clk_en_o); // R6
   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> !clk_en_o); // R4
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable({act_sel, act_d1, act_d2})); // R7
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !zero |-> (cnt1 < act_d1) && (cnt2 < act_d2)); // R3
endmodule

// File: rtl/clkgen_periph.sv
module clkgen_periph
   import clkgen_pkg::*;
#(
   parameter bit          MUX_EN     = 1'b1,
   parameter bit          DIV1_EN    = 1'b1,
   parameter bit          DIV2_EN    = 1'b1,
   parameter bit          GATE_EN    = 1'b1,
   parameter int unsigned SEL_SHIFT  = 4,
   parameter int unsigned DIV1_REG   = 2,
   parameter int unsigned DIV1_SHIFT = 3,
   parameter int unsigned DIV2_REG   = 2,
   parameter int unsigned DIV2_SHIFT = 0,
   parameter int unsigned GATE_BIT   = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  ref_stb,
   input  logic        xtal_stb,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [4:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        clk_en,
   output logic        out_valid
);
   localparam int unsigned NREF  = 4;
   localparam int unsigned SEL_W = $clog2(NREF);

   logic [1:0]       reg_sel;
   logic [SEL_W-1:0] mux_sel;
   logic [NREF-1:0]  mux_src;
   divcode_t         cfg_d1, cfg_d2;
   logic             gate_off, err_set;

   if (MUX_EN) begin : g_mux
      assign mux_src = ref_stb;
      assign mux_sel = reg_sel;
   end else begin : g_xtal
      assign mux_src = {NREF{xtal_stb}};
      assign mux_sel = '0;
   end

   clkgen_regs #(
      .SEL_SHIFT (SEL_SHIFT),
      .DIV1_REG  (DIV1_REG),
      .DIV1_SHIFT(DIV1_SHIFT),
      .DIV2_REG  (DIV2_REG),
      .DIV2_SHIFT(DIV2_SHIFT),
      .GATE_BIT  (GATE_BIT),
      .DIV1_EN   (DIV1_EN),
      .DIV2_EN   (DIV2_EN),
      .GATE_EN   (GATE_EN)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .err_set (err_set),
      .cfg_sel (reg_sel),
      .cfg_d1  (cfg_d1),
      .cfg_d2  (cfg_d2),
      .gate_off(gate_off)
   );

   clkgen_divchain #(
      .NSRC(NREF)
   ) i_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_stb  (mux_src),
      .cfg_sel  (mux_sel),
      .cfg_d1   (cfg_d1),
      .cfg_d2   (cfg_d2),
      .gate_off (gate_off),
      .clk_en_o (clk_en),
      .run_o    (out_valid),
      .err_set_o(err_set)
   );
endmodule

// File: tb/test_clkgen_periph.sv
module test_clkgen_periph;
   localparam int LIM = 2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ref_stb = '0;
   logic        xtal_stb = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_b;
   logic        clk_en, out_valid, clk_en_b, out_valid_b;

   int n_chk = 0, n_fail = 0;
   int exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   // reference i strobes every i+2 cycles; crystal every 3 cycles
   int rc[4] = '{0, 0, 0, 0};
   int xc = 0;
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         rc[i] = (rc[i] == i + 1) ? 0 : rc[i] + 1;
         ref_stb[i] = (rc[i] == 0);
      end
      xc = (xc == 2) ? 0 : xc + 1;
      xtal_stb = (xc == 0);
   end

   clkgen_periph i_clkgen_periph (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .xtal_stb(xtal_stb),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .clk_en(clk_en), .out_valid(out_valid));

   clkgen_periph #(.MUX_EN(1'b0), .DIV1_EN(1'b0)) i_clkgen_periph_byp (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .xtal_stb(xtal_stb),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata_b), .clk_en(clk_en_b), .out_valid(out_valid_b));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   function automatic logic en_of(input int which);
      return (which != 0) ? clk_en_b : clk_en;
   endfunction

   task automatic next_pulse(input int which);
      int n = 0;
      do begin @(negedge clk); n++; end while (!en_of(which) && n < LIM);
   endtask

   task automatic gap(input int which, output int g);
      g = 0;
      do begin @(negedge clk); g++; end while (!en_of(which) && g < LIM);
   endtask

   // monitor: pops expected periods and compares with measured gaps
   initial begin
      forever begin
         int g;
         wait (exp_q.size() > 0);
         next_pulse(0); next_pulse(0);
         gap(0, g);
         chk(g == exp_q[0], tag_q[0], g, exp_q[0]);
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   task automatic expect_gap(input int e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      wait (exp_q.size() == 0);
   endtask

   task automatic quiet(input int cycles, input string tag);
      int seen = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (clk_en) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int g1, g2;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(clk_en == 1'b0, "R9 clk_en in reset", clk_en, 0);
      chk(out_valid == 1'b1, "R9 out_valid in reset", out_valid, 1);
      rst_n = 1'b1;
      rd(5'h08, d); chk(d == 32'h9, "R9 divider reset value", d, 32'h9);
      rd(5'h18, d); chk(d == 32'h0, "R9 error clear", d, 0);
      rd(5'h14, d); chk(d == 32'h0, "R9 disable reset", d, 0);

      // R1 register access
      wr(5'h04, 32'hDEADBEEF);
      rd(5'h04, d); chk(d == 32'hDEADBEEF, "R1 readback", d, 32'hDEADBEEF);
      rd(5'h10, d); chk(d == 32'h0, "R1 unmapped", d, 0);

      // R3 ratio is the product of both codes (source 0, period 2)
      expect_gap(2, "R3 1x1");
      wr(5'h08, (2 << 3) | 3); expect_gap(12, "R3 2x3");
      wr(5'h08, (6 << 3) | 6); expect_gap(72, "R3 6x6");
      wr(5'h08, (5 << 3) | 1); expect_gap(10, "R3 5x1");

      // R2 source select
      wr(5'h08, (2 << 3) | 2);
      wr(5'h00, 32'h1 << 4); expect_gap(12, "R2 sel1");
      wr(5'h08, (1 << 3) | 3);
      wr(5'h00, 32'h3 << 4); expect_gap(15, "R2 sel3");

      // R7 change deferred to period boundary
      wr(5'h00, 32'h0);
      wr(5'h08, (2 << 3) | 3); expect_gap(12, "R7 settle");
      next_pulse(0);
      wr(5'h08, (1 << 3) | 1);
      gap(0, g1); g1 += 2;
      chk(g1 == 12, "R7 old period kept", g1, 12);
      gap(0, g2);
      chk(g2 == 2, "R7 new period", g2, 2);

      // R6 gate
      wr(5'h14, 32'h40);
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R6 out_valid gated", out_valid, 0);
      quiet(60, "R6 no pulses while gated");
      rd(5'h14, d); chk(d == 32'h40, "R6 disable readback", d, 32'h40);
      wr(5'h14, 32'h0); expect_gap(2, "R6 resume");

      // R4 / R5 invalid code and sticky error
      wr(5'h08, (7 << 3) | 2);
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R4 out_valid idle on code 7", out_valid, 0);
      quiet(60, "R4 no pulses on zero product");
      // R8 bypass instance ignores the first divider field
      chk(out_valid_b == 1'b1, "R8 bypass ignores d1", out_valid_b, 1);
      rd(5'h18, d); chk(d == 32'h1, "R5 error set", d, 1);
      wr(5'h18, 32'h1);
      rd(5'h18, d); chk(d == 32'h1, "R5 set wins over clear", d, 1);
      wr(5'h08, (1 << 3) | 2); expect_gap(4, "R4 recovered");
      wr(5'h18, 32'h1);
      rd(5'h18, d); chk(d == 32'h0, "R5 cleared", d, 0);

      // R8 crystal source, d1 bypassed: period = d2 * 3
      next_pulse(1); next_pulse(1);
      gap(1, g1); chk(g1 == 6, "R8 crystal d2=2", g1, 6);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule